// File: doc/BRIEF.md
# Paged Program Counter Unit

This block holds the instruction address of a small 8-bit controller core. It also holds a small latch register that supplies the upper address bits. The counter is 13 bits wide. Its low byte can be read by software and is overwritten when an ALU result targets it. The upper five bits are never written directly. They are taken from the latch, and which latch bits are used depends on how the counter is loaded.

Every clock edge is one instruction cycle. On each edge the counter does one of four things: it steps by one, takes a return address popped from the stack, takes a jump or call target built from an 11-bit immediate, or takes a new low byte from the ALU. On a call, the block offers the address of the next instruction on its push port. Instruction decode, the ALU and the stack storage sit outside the block.

Top module: `pc_paged_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the counter and the latch both become zero after that edge. This applies whatever other inputs are asserted.
- R2: When no load is requested, the counter adds one on each edge. 13'h1FFF is followed by 13'h0000.
- R3: A low-byte write loads the counter with the latch's five bits [4:0] as bits [12:8] and `lo_wr_data` as bits [7:0]. An offset that overflows the byte is not carried into the upper bits.
- R4: A jump or call loads bits [10:0] from `jmp_imm` and bits [12:11] from latch bits [4:3].
- R5: A return loads all 13 bits from `ret_addr`.
- R6: The latch changes only when `lat_wr_en` is high. Calls and returns leave it unchanged.
- R7: When several sources are requested, the one that wins is chosen in this order: reset, return, jump/call, low-byte write, increment.
- R8: `push_en_o` is high in the same cycle as an effective call, meaning `jmp_en` and `jmp_is_call` are high and `ret_en` and `rst` are low. In that cycle `push_addr_o` equals the counter plus one, wrapped to 13 bits. At all other times `push_en_o` is low.
- R9: `lo_byte_o` always shows counter bits [7:0].
- R10: If the latch is written in the same cycle as a jump or low-byte write, the load uses the latch value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| lat_wr_en | input | 1 | Write enable for the upper-bits latch |
| lat_wr_data | input | 5 | New latch value |
| lo_wr_en | input | 1 | ALU result targets the low byte |
| lo_wr_data | input | 8 | ALU result for the low byte |
| jmp_en | input | 1 | Jump or call in this cycle |
| jmp_is_call | input | 1 | The jump is a call, so a push is needed |
| jmp_imm | input | 11 | Immediate target field |
| ret_en | input | 1 | Return of any kind; pop the stack |
| ret_addr | input | 13 | Address popped from the stack |
| pc_o | output | 13 | Current counter |
| lo_byte_o | output | 8 | Readable low byte |
| lat_o | output | 5 | Current latch value |
| push_en_o | output | 1 | Push request to the stack |
| push_addr_o | output | 13 | Return address to push |

## Verification
The bench builds the block with the default widths: a 13-bit counter, an 8-bit low byte and an 11-bit immediate. With these widths the two page bits used by jumps are a strict subset of the five latch bits. A latch value such as 5'h15 therefore gives different upper bits for a low-byte write (5'h15) than for a jump (2'b10), and a single test can tell the two apart. A return to 13'h1FFE is used to bring the counter to the edge of its 13-bit range in a few cycles, so the wrap to zero and the push-address wrap can both be reached.

// File: rtl/pc_paged_pkg.sv
package pc_paged_pkg;
  typedef enum logic [2:0] {
    SRC_INC  = 3'd0,
    SRC_LOWR = 3'd1,
    SRC_JMP  = 3'd2,
    SRC_RET  = 3'd3,
    SRC_RST  = 3'd4
  } pc_src_e;
endpackage

// File: rtl/pc_src_arb.sv
module pc_src_arb
  import pc_paged_pkg::*;
(
  input  logic    rst,
  input  logic    ret_en,
  input  logic    jmp_en,
  input  logic    lo_wr_en,
  output pc_src_e src
);
  // fixed priority: reset, return, jump/call, low-byte write, increment
  always_comb begin
    if (rst)           src = SRC_RST;
    else if (ret_en)   src = SRC_RET;
    else if (jmp_en)   src = SRC_JMP;
    else if (lo_wr_en) src = SRC_LOWR;
    else               src = SRC_INC;
  end
endmodule

// File: rtl/pc_next_mux.sv
module pc_next_mux
  import pc_paged_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int LO_W  = 8,
  parameter int IMM_W = 11,
  localparam int LAT_W = PC_W - LO_W,
  localparam int PG_W  = PC_W - IMM_W
) (
  input  pc_src_e          src,
  input  logic [PC_W-1:0]  pc_q,
  input  logic [LAT_W-1:0] lat_q,
  input  logic [LO_W-1:0]  lo_wr_data,
  input  logic [IMM_W-1:0] jmp_imm,
  input  logic [PC_W-1:0]  ret_addr,
  output logic [PC_W-1:0]  pc_d
);
  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] pc_lowr;
  logic [PC_W-1:0] pc_jmp;

  assign pc_inc  = pc_q + PC_W'(1);
  // the low byte is replaced as a whole, so no carry reaches the upper bits
  assign pc_lowr = {lat_q, lo_wr_data};
  assign pc_jmp  = {lat_q[LAT_W-1 -: PG_W], jmp_imm};

  always_comb begin
    unique case (src)
      SRC_RST:  pc_d = '0;
      SRC_RET:  pc_d = ret_addr;
      SRC_JMP:  pc_d = pc_jmp;
      SRC_LOWR: pc_d = pc_lowr;
      default:  pc_d = pc_inc;
    endcase
  end
endmodule

// File: rtl/pc_hold_latch.sv
module pc_hold_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wr_data;
  end
endmodule

// File: rtl/pc_paged_unit.sv
module pc_paged_unit
  import pc_paged_pkg::*;
#(
  parameter int PC_W  = 13,
  parameter int LO_W  = 8,
  parameter int IMM_W = 11,
  localparam int LAT_W = PC_W - LO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lat_wr_en,
  input  logic [LAT_W-1:0] lat_wr_data,
  input  logic             lo_wr_en,
  input  logic [LO_W-1:0]  lo_wr_data,
  input  logic             jmp_en,
  input  logic             jmp_is_call,
  input  logic [IMM_W-1:0] jmp_imm,
  input  logic             ret_en,
  input  logic [PC_W-1:0]  ret_addr,
  output logic [PC_W-1:0]  pc_o,
  output logic [LO_W-1:0]  lo_byte_o,
  output logic [LAT_W-1:0] lat_o,
  output logic             push_en_o,
  output logic [PC_W-1:0]  push_addr_o
);
  pc_src_e         src;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [LAT_W-1:0] lat_q;

  pc_src_arb u_arb (
    .rst      (rst),
    .ret_en   (ret_en),
    .jmp_en   (jmp_en),
    .lo_wr_en (lo_wr_en),
    .src      (src)
  );

  pc_hold_latch #(.W(LAT_W)) u_lat (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (lat_wr_en),
    .wr_data (lat_wr_data),
    .q       (lat_q)
  );

  pc_next_mux #(.PC_W(PC_W), .LO_W(LO_W), .IMM_W(IMM_W)) u_mux (
    .src        (src),
    .pc_q       (pc_q),
    .lat_q      (lat_q),
    .lo_wr_data (lo_wr_data),
    .jmp_imm    (jmp_imm),
    .ret_addr   (ret_addr),
    .pc_d       (pc_d)
  );

  always_ff @(posedge clk) begin
    pc_q <= pc_d;
  end

  assign pc_o        = pc_q;
  assign lo_byte_o   = pc_q[LO_W-1:0];
  assign lat_o       = lat_q;
  assign push_en_o   = (src == SRC_JMP) && jmp_is_call;
  assign push_addr_o = pc_q + PC_W'(1);
endmodule

// File: rtl/pc_paged_unit_chk.sv
module pc_paged_unit_chk #(
  parameter int PC_W  = 13,
  parameter int LO_W  = 8,
  parameter int IMM_W = 11,
  localparam int LAT_W = PC_W - LO_W,
  localparam int PG_W  = PC_W - IMM_W
) (
  input logic             clk,
  input logic             rst,
  input logic             lat_wr_en,
  input logic             lo_wr_en,
  input logic [LO_W-1:0]  lo_wr_data,
  input logic             jmp_en,
  input logic             jmp_is_call,
  input logic [IMM_W-1:0] jmp_imm,
  input logic             ret_en,
  input logic [PC_W-1:0]  ret_addr,
  input logic [PC_W-1:0]  pc_o,
  input logic [LO_W-1:0]  lo_byte_o,
  input logic [LAT_W-1:0] lat_o,
  input logic             push_en_o,
  input logic [PC_W-1:0]  push_addr_o
);
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc_o == '0 && lat_o == '0));

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!ret_en && !jmp_en && !lo_wr_en) |=> pc_o == PC_W'($past(pc_o) + 1'b1));

  p_lowr_r3: assert property (@(posedge clk) disable iff (rst)
    (lo_wr_en && !jmp_en && !ret_en) |=> pc_o == {$past(lat_o), $past(lo_wr_data)});

  p_jump_r4: assert property (@(posedge clk) disable iff (rst)
    (jmp_en && !ret_en) |=> pc_o == {$past(lat_o[LAT_W-1 -: PG_W]), $past(jmp_imm)});

  p_ret_r5: assert property (@(posedge clk) disable iff (rst)
    ret_en |=> pc_o == $past(ret_addr));

  p_lat_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !lat_wr_en |=> $stable(lat_o));

  p_push_r8: assert property (@(posedge clk) disable iff (rst)
    push_en_o |-> (push_addr_o == PC_W'(pc_o + 1'b1) && jmp_is_call && !ret_en));

  p_lobyte_r9: assert property (@(posedge clk)
    lo_byte_o == pc_o[LO_W-1:0]);
endmodule

bind pc_paged_unit pc_paged_unit_chk #(.PC_W(PC_W), .LO_W(LO_W), .IMM_W(IMM_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .lat_wr_en   (lat_wr_en),
  .lo_wr_en    (lo_wr_en),
  .lo_wr_data  (lo_wr_data),
  .jmp_en      (jmp_en),
  .jmp_is_call (jmp_is_call),
  .jmp_imm     (jmp_imm),
  .ret_en      (ret_en),
  .ret_addr    (ret_addr),
  .pc_o        (pc_o),
  .lo_byte_o   (lo_byte_o),
  .lat_o       (lat_o),
  .push_en_o   (push_en_o),
  .push_addr_o (push_addr_o)
);

// File: tb/pc_paged_unit_tb.sv
module pc_paged_unit_tb_top;
  localparam int PC_W  = 13;
  localparam int LO_W  = 8;
  localparam int IMM_W = 11;
  localparam int LAT_W = PC_W - LO_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lat_wr_en = 1'b0;
  logic [LAT_W-1:0] lat_wr_data = '0;
  logic lo_wr_en = 1'b0;
  logic [LO_W-1:0] lo_wr_data = '0;
  logic jmp_en = 1'b0;
  logic jmp_is_call = 1'b0;
  logic [IMM_W-1:0] jmp_imm = '0;
  logic ret_en = 1'b0;
  logic [PC_W-1:0] ret_addr = '0;
  logic [PC_W-1:0] pc_o;
  logic [LO_W-1:0] lo_byte_o;
  logic [LAT_W-1:0] lat_o;
  logic push_en_o;
  logic [PC_W-1:0] push_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pc_paged_unit #(.PC_W(PC_W), .LO_W(LO_W), .IMM_W(IMM_W)) dut_i (
    .clk(clk), .rst(rst),
    .lat_wr_en(lat_wr_en), .lat_wr_data(lat_wr_data),
    .lo_wr_en(lo_wr_en), .lo_wr_data(lo_wr_data),
    .jmp_en(jmp_en), .jmp_is_call(jmp_is_call), .jmp_imm(jmp_imm),
    .ret_en(ret_en), .ret_addr(ret_addr),
    .pc_o(pc_o), .lo_byte_o(lo_byte_o), .lat_o(lat_o),
    .push_en_o(push_en_o), .push_addr_o(push_addr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    rst = 1'b0; lat_wr_en = 1'b0; lo_wr_en = 1'b0;
    jmp_en = 1'b0; jmp_is_call = 1'b0; ret_en = 1'b0;
  endtask

  task automatic go_to(input logic [PC_W-1:0] a);
    idle(); ret_en = 1'b1; ret_addr = a; cyc(); idle();
  endtask

  task automatic set_lat(input logic [LAT_W-1:0] v);
    idle(); lat_wr_en = 1'b1; lat_wr_data = v; cyc(); idle();
  endtask

  task automatic t_reset();
    rst = 1'b1; cyc(); cyc();
    chk("R1 pc after reset", 32'(pc_o), 0);
    chk("R1 latch after reset", 32'(lat_o), 0);
    idle(); cyc();
    chk("R2 first step", 32'(pc_o), 1);
    cyc();
    chk("R2 second step", 32'(pc_o), 2);
  endtask

  task automatic t_wrap();
    go_to(13'h1FFE);
    chk("R5 return load", 32'(pc_o), 32'h1FFE);
    cyc();
    chk("R2 reach top", 32'(pc_o), 32'h1FFF);
    cyc();
    chk("R2 wrap to zero", 32'(pc_o), 0);
  endtask

  task automatic t_lowr();
    logic [LO_W-1:0] sum;
    set_lat(5'h15);
    lo_wr_en = 1'b1; lo_wr_data = 8'h3C; cyc(); idle();
    chk("R3 low-byte write", 32'(pc_o), 32'h153C);
    chk("R9 low byte readable", 32'(lo_byte_o), 32'h3C);
    sum = LO_W'(8'hF0 + 8'h20);
    lo_wr_en = 1'b1; lo_wr_data = sum; cyc(); idle();
    chk("R3 table wraps in block", 32'(pc_o), 32'h1510);
  endtask

  task automatic t_jump();
    set_lat(5'h15);
    jmp_en = 1'b1; jmp_imm = 11'h2AB; cyc(); idle();
    chk("R4 jump page bits", 32'(pc_o), 32'({2'b10, 11'h2AB}));
    jmp_en = 1'b1; jmp_imm = 11'h2AB; lat_wr_en = 1'b1; lat_wr_data = 5'h08; cyc(); idle();
    chk("R10 jump uses old latch", 32'(pc_o), 32'({2'b10, 11'h2AB}));
    chk("R10 latch written", 32'(lat_o), 32'h08);
    jmp_en = 1'b1; jmp_imm = 11'h2AB; cyc(); idle();
    chk("R4 jump new page", 32'(pc_o), 32'({2'b01, 11'h2AB}));
    lo_wr_en = 1'b1; lo_wr_data = 8'h77; lat_wr_en = 1'b1; lat_wr_data = 5'h1F; cyc(); idle();
    chk("R10 low write uses old latch", 32'(pc_o), 32'h0877);
  endtask

  task automatic t_call();
    set_lat(5'h00);
    go_to(13'h0123);
    jmp_en = 1'b1; jmp_is_call = 1'b1; jmp_imm = 11'h456; #1;
    chk("R8 push enable", 32'(push_en_o), 1);
    chk("R8 push address", 32'(push_addr_o), 32'h0124);
    cyc(); idle(); #1;
    chk("R4 call target", 32'(pc_o), 32'h0456);
    chk("R8 no push when idle", 32'(push_en_o), 0);
    go_to(13'h1FFF);
    jmp_en = 1'b1; jmp_is_call = 1'b1; jmp_imm = 11'h001; #1;
    chk("R8 push address wraps", 32'(push_addr_o), 0);
    cyc(); idle();
  endtask

  task automatic t_ret_latch();
    set_lat(5'h1A);
    jmp_en = 1'b1; jmp_is_call = 1'b1; jmp_imm = 11'h010; cyc(); idle();
    chk("R6 latch kept over call", 32'(lat_o), 32'h1A);
    go_to(13'h0777);
    chk("R5 return full address", 32'(pc_o), 32'h0777);
    chk("R6 latch kept over return", 32'(lat_o), 32'h1A);
  endtask

  task automatic t_prio();
    set_lat(5'h00);
    ret_en = 1'b1; ret_addr = 13'h0ABC; jmp_en = 1'b1; jmp_is_call = 1'b1;
    jmp_imm = 11'h111; lo_wr_en = 1'b1; lo_wr_data = 8'h22; #1;
    chk("R8 no push under return", 32'(push_en_o), 0);
    cyc(); idle();
    chk("R7 return wins", 32'(pc_o), 32'h0ABC);
    jmp_en = 1'b1; jmp_imm = 11'h333; lo_wr_en = 1'b1; lo_wr_data = 8'h44; cyc(); idle();
    chk("R7 jump beats low write", 32'(pc_o), 32'h0333);
    lo_wr_en = 1'b1; lo_wr_data = 8'h55; cyc(); idle();
    chk("R7 low write beats step", 32'(pc_o), 32'h0055);
  endtask

  task automatic t_reset_mid();
    set_lat(5'h1F);
    rst = 1'b1; ret_en = 1'b1; ret_addr = 13'h1234; jmp_en = 1'b1; jmp_is_call = 1'b1; #1;
    chk("R8 no push under reset", 32'(push_en_o), 0);
    cyc(); idle();
    chk("R1 reset beats return", 32'(pc_o), 0);
    chk("R1 reset clears latch", 32'(lat_o), 0);
  endtask

  initial begin
    idle(); rst = 1'b1;
    t_reset();
    t_wrap();
    t_lowr();
    t_jump();
    t_call();
    t_ret_latch();
    t_prio();
    t_reset_mid();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule